// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog peripheral built around one 16-bit control word held behind a plain synchronous write port. Software can only change that word after first writing a two-word unlock key. A second two-word key restarts the count and leaves the control word as it is. Once armed, the counter advances on an external base tick strobe. When it reaches the period chosen by a one-hot timeout field, the block issues a one-cycle system reset request and latches a sticky expired flag.

An external inhibit input freezes the write port. While it is high, writes are dropped and the key tracker keeps its position, so the surrounding system can fence the watchdog off. The exponent of the shortest period is a parameter, so a bench can shrink the timeouts without touching the logic.

Top module: `kwdt_top`

## Requirements
- R1: A write to the control address loads the control word only when the two writes just before it were 0x3333 and then 0xCCCC, both to the control address. The new word appears on `rd_ctrl` in the cycle after the loading write.
- R2: Writing 0xAAAA and then, as the very next write, 0x5555 to the control address restarts the counter from zero and leaves the control word unchanged.
- R3: Control bits 7:1 form a one-hot timeout field. Bit k (1..7) selects a period of 2^(EXP_BASE+k-1) ticks. The counter advances only on cycles with `tick` high while bit 15 (enable) is set.
- R4: When the last tick of the period is counted and bit 14 (reset select) is set, `reset_req` is high for exactly one cycle, in the cycle after that tick, and `rd_expired` rises together with it and stays high until reset. With bit 14 clear the counter wraps to zero and raises neither signal.
- R5: A keyed write with bit 15 set whose bits 7:1 do not hold exactly one set bit is rejected, and the control word keeps its old value.
- R6: A keyed write of 0x4080 disables the watchdog. While bit 15 is clear no tick leads to a reset request.
- R7: While `echo_inhibit` is high, writes are ignored and the key tracker keeps its position.
- R8: A write that breaks a key sequence, whether it carries a wrong value or goes to another address, returns the tracker to idle and has no other effect.
- R9: A write of any value other than 0x3333 or 0xAAAA to the control address, without a preceding key, is discarded.
- R10: While `rst_n` is low at a clock edge, the control word (0x0000), the expired flag, the counter, the reset request and the key tracker are all cleared.
- R11: If the 0x5555 write that completes a restart falls in the same cycle as the tick that would end the period, the restart wins and no reset request is raised.
- R12: Every accepted configuration write restarts the counter from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address; CTRL_ADDR selects the control word |
| wr_data | input | 16 | Write data |
| echo_inhibit | input | 1 | High blocks all writes and freezes the key tracker |
| tick | input | 1 | Base tick enable for the counter |
| rd_ctrl | output | 16 | Current control word |
| rd_expired | output | 1 | Sticky expiry flag |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
Two functions can act in the same cycle: the restart key completing, and the counter taking the final tick of its period. The bench provokes this by counting one tick short of the period and then issuing 0x5555 with `tick` high in that same cycle. A behavioural model, which gives the restart priority, then predicts no pulse, and the pulse only arrives a full period later. The same overlap is also provoked between an accepted configuration write and an accumulated count, and the bench judges it by when the next reset request appears.

// File: rtl/kwdt_pkg.sv
// Package: shared constants and types for the keyed watchdog.
// Assumes a 16-bit control word; key values are fixed by the access protocol.
package kwdt_pkg;

    localparam int DATA_W  = 16;
    localparam int EN_BIT  = 15;   // counting enable
    localparam int RST_BIT = 14;   // reset request on expiry
    localparam int TO_LSB  = 1;    // lowest bit of one-hot timeout field
    localparam int TO_W    = 7;    // width of one-hot timeout field

    localparam logic [DATA_W-1:0] KEY_CFG_A = 16'h3333;
    localparam logic [DATA_W-1:0] KEY_CFG_B = 16'hCCCC;
    localparam logic [DATA_W-1:0] KEY_RST_A = 16'hAAAA;
    localparam logic [DATA_W-1:0] KEY_RST_B = 16'h5555;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,   // no key in progress
        SEQ_CFG1  = 2'd1,   // first unlock word seen
        SEQ_OPEN  = 2'd2,   // unlocked, next write is configuration
        SEQ_RFR1  = 2'd3    // first restart word seen
    } seq_state_t;

endpackage

// File: rtl/kwdt_keyseq.sv
// Module: key-sequence tracker.
// Watches writes to the control address and turns unlock and restart key pairs
// into a configuration strobe and a restart pulse. Assumes one write per cycle
// at most; inhibit freezes the tracker completely.
module kwdt_keyseq
    import kwdt_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inhibit,
    output logic              cfg_strobe,
    output logic              restart
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    seq_state_t state_q, state_d;
    logic       wr_ok;
    logic       addr_hit;

    assign wr_ok    = wr_en && !inhibit;
    assign addr_hit = (wr_addr == CTRL_A);

    // Next-state selection for the key tracker.
    always_comb begin
        state_d = state_q;
        if (wr_ok) begin
            if (!addr_hit) begin
                state_d = SEQ_IDLE;
            end else begin
                unique case (state_q)
                    SEQ_IDLE: begin
                        if (wr_data == KEY_CFG_A)      state_d = SEQ_CFG1;
                        else if (wr_data == KEY_RST_A) state_d = SEQ_RFR1;
                        else                           state_d = SEQ_IDLE;
                    end
                    SEQ_CFG1: state_d = (wr_data == KEY_CFG_B) ? SEQ_OPEN : SEQ_IDLE;
                    SEQ_OPEN: state_d = SEQ_IDLE;
                    SEQ_RFR1: state_d = SEQ_IDLE;
                    default:  state_d = SEQ_IDLE;
                endcase
            end
        end
    end

    // Tracker state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    assign cfg_strobe = wr_ok && addr_hit && (state_q == SEQ_OPEN);
    assign restart    = wr_ok && addr_hit && (state_q == SEQ_RFR1) && (wr_data == KEY_RST_B);

    // R7: inhibited writes leave the tracker where it was.
    assert_inhibit_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && inhibit) |=> $stable(state_q));

    // R8: a write to another address always drops the tracker to idle.
    assert_foreign_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !inhibit && (wr_addr != CTRL_A)) |=> (state_q == SEQ_IDLE));

endmodule

// File: rtl/kwdt_ctrl.sv
// Module: control word register.
// Loads a keyed configuration when it is valid (enable clear, or enable set
// with exactly one timeout bit). Assumes cfg_strobe comes from the key tracker.
module kwdt_ctrl
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_strobe,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cfg_taken,
    output logic [DATA_W-1:0] ctrl_q
);

    logic cfg_valid;

    // Validity check of a candidate configuration word.
    always_comb begin
        cfg_valid = !wr_data[EN_BIT] || $onehot(wr_data[TO_LSB +: TO_W]);
    end

    assign cfg_taken = cfg_strobe && cfg_valid;

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctrl_q <= '0;
        else if (cfg_taken) ctrl_q <= wr_data;
    end

    // R1: the control word changes only on a keyed configuration write.
    assert_cfg_needs_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (ctrl_q != $past(ctrl_q))) |-> $past(cfg_strobe));

    // R5: an enabled control word always carries a single timeout bit.
    assert_enabled_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[EN_BIT] |-> $onehot(ctrl_q[TO_LSB +: TO_W]));

endmodule

// File: rtl/kwdt_counter.sv
// Module: tick counter and expiry detection.
// Counts base ticks while enabled and compares against the period chosen by
// the one-hot select. Restart and configuration clear take priority over a tick.
module kwdt_counter #(
    parameter int EXP_BASE = 24,
    parameter int NUM_SEL  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               rst_sel,
    input  logic [NUM_SEL-1:0] sel,
    input  logic               tick,
    input  logic               clear,
    output logic               reset_req,
    output logic               expired
);

    localparam int CNT_W = EXP_BASE + NUM_SEL - 1;

    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_SEL-1:0] hit;
    logic               term;
    logic               fire;

    // One terminal-count detector per selectable period.
    for (genvar k = 0; k < NUM_SEL; k++) begin : g_term
        localparam int E = EXP_BASE + k;
        assign hit[k] = sel[k] && (&cnt_q[E-1:0]);
    end

    assign term = |hit;
    assign fire = !clear && en && tick && term;

    // Tick counter with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (clear || !en)     cnt_q <= '0;
        else if (tick && term)     cnt_q <= '0;
        else if (tick)             cnt_q <= cnt_q + CNT_W'(1);
    end

    // Reset request pulse and sticky expiry flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req <= 1'b0;
            expired   <= 1'b0;
        end else begin
            reset_req <= fire && rst_sel;
            if (fire && rst_sel) expired <= 1'b1;
        end
    end

    // R4: the reset request is a single-cycle pulse.
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    // R4: the expiry flag is set whenever a request is out.
    assert_req_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> expired);

    // R2, R12: a clear leaves the counter at zero.
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

    // R6: no request follows a disabled cycle.
    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !reset_req);

endmodule

// File: rtl/kwdt_top.sv
// Module: keyed-access watchdog top level.
// Ties the key tracker, control word and counter together. Assumes writes are
// already decoded to this block's address window and tick is a one-cycle strobe.
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0,
    parameter int EXP_BASE  = 24,
    parameter int NUM_SEL   = TO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              echo_inhibit,
    input  logic              tick,
    output logic [15:0]       rd_ctrl,
    output logic              rd_expired,
    output logic              reset_req
);

    logic              cfg_strobe;
    logic              restart;
    logic              cfg_taken;
    logic [DATA_W-1:0] ctrl_q;

    kwdt_keyseq #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_keyseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .inhibit    (echo_inhibit),
        .cfg_strobe (cfg_strobe),
        .restart    (restart)
    );

    kwdt_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_strobe (cfg_strobe),
        .wr_data    (wr_data),
        .cfg_taken  (cfg_taken),
        .ctrl_q     (ctrl_q)
    );

    kwdt_counter #(
        .EXP_BASE (EXP_BASE),
        .NUM_SEL  (NUM_SEL)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl_q[EN_BIT]),
        .rst_sel   (ctrl_q[RST_BIT]),
        .sel       (ctrl_q[TO_LSB +: NUM_SEL]),
        .tick      (tick),
        .clear     (restart || cfg_taken),
        .reset_req (reset_req),
        .expired   (rd_expired)
    );

    assign rd_ctrl = ctrl_q;

    // R11: a restart in the final-tick cycle suppresses the request.
    assert_restart_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !reset_req);

endmodule

// File: tb/kwdt_top_tb.sv
// Bench: behavioural reference model compared on every clock, plus targeted checks.
module kwdt_top_tb;

    localparam int ADDR_W = 4;
    localparam int EXPB   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [15:0]       wr_data = '0;
    logic              echo_inhibit = 1'b0;
    logic              tick = 1'b0;
    logic [15:0]       rd_ctrl;
    logic              rd_expired;
    logic              reset_req;

    always #2.5 clk = ~clk;

    kwdt_top #(.ADDR_W(ADDR_W), .CTRL_ADDR(0), .EXP_BASE(EXPB)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .echo_inhibit(echo_inhibit), .tick(tick),
        .rd_ctrl(rd_ctrl), .rd_expired(rd_expired), .reset_req(reset_req)
    );

    int    vectors = 0;
    int    misses  = 0;
    int    pulses  = 0;
    int    cycles  = 0;
    string phase   = "R10";

    // Reference model state
    int          m_st = 0;
    logic [15:0] m_ctrl = '0;
    longint      m_cnt = 0;
    logic        m_exp = 1'b0;
    logic        m_rr  = 1'b0;

    function automatic bit one_bit(input logic [6:0] f);
        int n = 0;
        for (int i = 0; i < 7; i++) if (f[i]) n++;
        return n == 1;
    endfunction

    function automatic longint period_of(input logic [15:0] c);
        for (int k = 1; k <= 7; k++) if (c[k]) return longint'(1) << (EXPB + k - 1);
        return 0;
    endfunction

    always @(posedge clk) begin
        bit clr;
        bit rr_n;
        logic [15:0] old_ctrl;
        clr = 0; rr_n = 0; old_ctrl = m_ctrl;
        if (!rst_n) begin
            m_st = 0; m_ctrl = '0; m_cnt = 0; m_exp = 0; m_rr = 0;
        end else begin
            if (wr_en && !echo_inhibit) begin
                if (wr_addr != 0) m_st = 0;
                else begin
                    case (m_st)
                        0: m_st = (wr_data == 16'h3333) ? 1 : (wr_data == 16'hAAAA) ? 3 : 0;
                        1: m_st = (wr_data == 16'hCCCC) ? 2 : 0;
                        2: begin
                            if (!wr_data[15] || one_bit(wr_data[7:1])) begin
                                m_ctrl = wr_data; clr = 1;
                            end
                            m_st = 0;
                        end
                        default: begin
                            if (wr_data == 16'h5555) clr = 1;
                            m_st = 0;
                        end
                    endcase
                end
            end
            if (clr || !old_ctrl[15]) m_cnt = 0;
            else if (tick) begin
                if (m_cnt == period_of(old_ctrl) - 1) begin
                    m_cnt = 0;
                    if (old_ctrl[14]) begin rr_n = 1; m_exp = 1; end
                end else m_cnt++;
            end
            m_rr = rr_n;
        end
    end

    // Every-cycle comparison against the model, plus the watchdog.
    always @(negedge clk) begin
        cycles++;
        if (reset_req) pulses++;
        vectors++;
        if (rd_ctrl !== m_ctrl || rd_expired !== m_exp || reset_req !== m_rr) begin
            misses++;
            $display("FAIL %s: ctrl=%h exp=%b req=%b expected ctrl=%h exp=%b req=%b",
                     phase, rd_ctrl, rd_expired, reset_req, m_ctrl, m_exp, m_rr);
        end
        if (cycles > 100000) begin
            misses++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    task automatic check(input string tag, input longint got, input longint exp);
        vectors++;
        if (got != exp) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d, input bit tk = 0);
        @(negedge clk);
        wr_en <= 1'b1; wr_addr <= a; wr_data <= d; tick <= tk;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en <= 1'b0; tick <= 1'b1;
        end
    endtask

    task automatic settle();
        repeat (2) begin
            @(negedge clk);
            wr_en <= 1'b0; tick <= 1'b0;
        end
    endtask

    task automatic config_wr(input logic [15:0] d);
        wr(0, 16'h3333); wr(0, 16'hCCCC); wr(0, d);
    endtask

    task automatic restart_wr(input bit tk);
        wr(0, 16'hAAAA); wr(0, 16'h5555, tk);
    endtask

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        rst_n <= 1'b1;
        settle();
        phase = "R10";
        check("R10 ctrl", rd_ctrl, 16'h0000);
        check("R10 expired", rd_expired, 0);
        check("R10 reset_req", reset_req, 0);

        phase = "R9";
        wr(0, 16'hC004); wr(0, 16'h1234); settle();
        check("R9 unkeyed discarded", rd_ctrl, 16'h0000);

        phase = "R4";
        config_wr(16'h8002); settle();
        check("R1 load wrap cfg", rd_ctrl, 16'h8002);
        p0 = pulses; ticks(9); settle();
        check("R4 no req when reset select clear", pulses - p0, 0);
        check("R4 expired stays low", rd_expired, 0);

        phase = "R3";
        config_wr(16'hC004); settle();
        check("R1 keyed load", rd_ctrl, 16'hC004);
        p0 = pulses; ticks(7); settle();
        check("R3 no req before period", pulses - p0, 0);
        ticks(1); settle();
        check("R4 req after 8 ticks", pulses - p0, 1);
        check("R4 expired sticky", rd_expired, 1);
        tick <= 1'b0;

        phase = "R2";
        p0 = pulses; ticks(6); restart_wr(0); ticks(6); settle();
        check("R2 restart delays request", pulses - p0, 0);
        check("R2 ctrl unchanged", rd_ctrl, 16'hC004);
        ticks(2); settle();
        check("R2 request after fresh period", pulses - p0, 1);

        phase = "R11";
        p0 = pulses; ticks(7); restart_wr(1); settle();
        check("R11 restart wins same cycle", pulses - p0, 0);
        ticks(7); settle();
        check("R11 still counting", pulses - p0, 0);
        ticks(1); settle();
        check("R11 request one period later", pulses - p0, 1);

        phase = "R7";
        echo_inhibit <= 1'b1;
        config_wr(16'hC008); settle();
        check("R7 inhibited write ignored", rd_ctrl, 16'hC004);
        echo_inhibit <= 1'b0;
        wr(0, 16'h3333);
        @(negedge clk); echo_inhibit <= 1'b1; wr_en <= 1'b1; wr_data <= 16'h0BAD;
        @(negedge clk); echo_inhibit <= 1'b0; wr_data <= 16'hCCCC;
        wr(0, 16'hC008); settle();
        check("R7 tracker held across inhibit", rd_ctrl, 16'hC008);

        phase = "R3";
        p0 = pulses; ticks(15); settle();
        check("R3 bit3 no early req", pulses - p0, 0);
        ticks(1); settle();
        check("R3 bit3 period 16", pulses - p0, 1);

        phase = "R8";
        wr(0, 16'h3333); wr(5, 16'h0000); wr(0, 16'hCCCC); wr(0, 16'hC002); settle();
        check("R8 foreign address breaks key", rd_ctrl, 16'hC008);
        wr(0, 16'h3333); wr(0, 16'h1234); wr(0, 16'hCCCC); wr(0, 16'hC002); settle();
        check("R8 wrong value breaks key", rd_ctrl, 16'hC008);

        phase = "R5";
        config_wr(16'hC006); settle();
        check("R5 two timeout bits rejected", rd_ctrl, 16'hC008);
        config_wr(16'hC000); settle();
        check("R5 no timeout bit rejected", rd_ctrl, 16'hC008);

        phase = "R12";
        config_wr(16'hC002); settle();
        p0 = pulses; ticks(3); config_wr(16'hC002); ticks(3); settle();
        check("R12 config restarts count", pulses - p0, 0);
        ticks(1); settle();
        check("R12 request after full period", pulses - p0, 1);

        phase = "R6";
        config_wr(16'h4080); settle();
        check("R6 disable word loaded", rd_ctrl, 16'h4080);
        p0 = pulses; ticks(300); settle();
        check("R6 disabled no request", pulses - p0, 0);

        phase = "R10";
        rst_n <= 1'b0; settle(); rst_n <= 1'b1; settle();
        check("R10 ctrl after reset", rd_ctrl, 16'h0000);
        check("R10 expired after reset", rd_expired, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule